// File: doc/BRIEF.md
# Slave-Mode Clocked Up-Counter with Trigger Selection

This block is a 16-bit up-counter whose count clock is picked by a slave-mode field. In internal mode the counter steps once on every system clock while it is enabled. In external-edge mode it steps once on each active edge of a trigger. That trigger is chosen by a trigger-select field from four synchronous inputs: a primary timer input, a secondary timer input, an internal trigger and an external trigger.

Each timer input and the external trigger first pass through a programmable glitch filter, followed by an edge detector. The secondary timer input has a polarity bit that picks its rising or its falling edge. Each counting trigger edge sets a sticky flag, which a clear strobe resets. An update pulse returns the counter to zero. When the counter wraps, the block raises a one-cycle wrap pulse.

Top module: `timer_slave_count`

## Requirements
- R1: With `slaveMode` = 3'b000 and `countEn` = 1, `count` increases by one on every clock edge.
- R2: With `countEn` = 0, `count` holds and `trigFlag` is not set, in every mode and on any trigger edge.
- R3: Any `slaveMode` other than 3'b000 and 3'b111 keeps `count` stopped.
- R4: With `slaveMode` = 3'b111, `trigSel` = 3'b110 and `tiBFall` = 0, each rising edge of filtered `tiB` adds exactly one. With a filter length of zero, a level taken in at clock edge k shows in `count` at edge k+1.
- R5: With `trigSel` = 3'b110 and `tiBFall` = 1, only the falling edges of filtered `tiB` count.
- R6: `trigSel` = 3'b100 counts both the rising and the falling edges of filtered `tiA`.
- R7: `trigSel` = 3'b101 counts rising edges of filtered `tiA`. 3'b001 counts rising edges of `intTrig`, which is registered but not filtered. 3'b111 counts rising edges of filtered `extTrig`. Every other `trigSel` code never counts.
- R8: With `filtLen` = N, a new input level must be sampled on N+1 consecutive clock edges before the filtered signal changes. A shorter pulse causes no count.
- R9: A counting trigger edge sets the sticky `trigFlag`. A `flagClr` strobe clears it. If both happen in the same cycle, the flag ends up set.
- R10: `updGen` loads `count` with zero at the next edge, taking priority over any increment.
- R11: An increment at 16'hFFFF wraps `count` to 16'h0000. `wrapPulse` is high for exactly the one cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 3 | Count clock: 000 internal, 111 trigger edges, other values stopped |
| trigSel | input | 3 | Trigger source select (see R4 to R7) |
| tiBFall | input | 1 | Edge polarity of `tiB`: 0 rising, 1 falling |
| filtLen | input | 4 | Glitch filter length N; 0 means no filtering |
| countEn | input | 1 | Counter enable |
| updGen | input | 1 | Pulse that reinitialises the counter to zero |
| flagClr | input | 1 | Clear strobe for the trigger flag |
| tiA | input | 1 | Primary timer input, synchronous |
| tiB | input | 1 | Secondary timer input, synchronous |
| intTrig | input | 1 | Internal trigger, synchronous |
| extTrig | input | 1 | External trigger, synchronous |
| count | output | 16 | Counter value |
| trigFlag | output | 1 | Sticky trigger flag |
| wrapPulse | output | 1 | One-cycle pulse after a wrap |

## Verification
The assertions assume that every input is already synchronous to `clk`, and that `filtLen` and `trigSel` are not changed while a filtered input is partway through a transition. The stimulus changes inputs only on falling clock edges. It changes the filter length and the selectors only while all trigger inputs are idle low and settled. Each pulse is held low long enough for the filter to return before the next pulse begins, so every edge the bench expects is one the filter is able to pass.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam logic [2:0] MODE_INT  = 3'b000;
  localparam logic [2:0] MODE_EXT1 = 3'b111;

  localparam logic [2:0] TS_ITR   = 3'b001;
  localparam logic [2:0] TS_ABOTH = 3'b100;
  localparam logic [2:0] TS_AFILT = 3'b101;
  localparam logic [2:0] TS_BFILT = 3'b110;
  localparam logic [2:0] TS_EXT   = 3'b111;

  localparam int NUM_SRC = 4;
  localparam int SRC_ITR = 0;
  localparam int SRC_A   = 1;
  localparam int SRC_B   = 2;
  localparam int SRC_EXT = 3;

  typedef struct packed {
    logic inc;
    logic reinit;
    logic setFlag;
    logic clrFlag;
  } ctrlStrb_t;
endpackage

// File: rtl/tss_filter.sv
module tss_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILT_W-1:0] len,
  input  logic              rawIn,
  output logic              filtOut
);
  logic [FILT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtOut <= 1'b0;
      runCnt  <= '0;
    end else if (rawIn == filtOut) begin
      runCnt <= '0;
    end else if (runCnt == len) begin
      filtOut <= rawIn;
      runCnt  <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R8
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtOut) |-> filtOut == $past(rawIn));
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         slaveMode,
  input  logic [2:0]         trigSel,
  input  logic               tiBFall,
  input  logic               countEn,
  input  logic               updGen,
  input  logic               flagClr,
  input  logic [NUM_SRC-1:0] filtSrc,
  output ctrlStrb_t          strb
);
  logic [NUM_SRC-1:0] prevSrc;
  logic [NUM_SRC-1:0] riseEdge;
  logic [NUM_SRC-1:0] fallEdge;
  logic               bEdge;
  logic               selEdge;
  logic               intMode;
  logic               extMode;

  always_ff @(posedge clk) begin
    if (!rstN) prevSrc <= '0;
    else       prevSrc <= filtSrc;
  end

  assign riseEdge = filtSrc & ~prevSrc;
  assign fallEdge = ~filtSrc & prevSrc;
  assign bEdge    = tiBFall ? fallEdge[SRC_B] : riseEdge[SRC_B];

  always_comb begin
    unique case (trigSel)
      TS_ITR:   selEdge = riseEdge[SRC_ITR];
      TS_ABOTH: selEdge = riseEdge[SRC_A] | fallEdge[SRC_A];
      TS_AFILT: selEdge = riseEdge[SRC_A];
      TS_BFILT: selEdge = bEdge;
      TS_EXT:   selEdge = riseEdge[SRC_EXT];
      default:  selEdge = 1'b0;
    endcase
  end

  assign intMode = (slaveMode == MODE_INT);
  assign extMode = (slaveMode == MODE_EXT1);

  always_comb begin
    strb.inc     = countEn & (intMode | (extMode & selEdge));
    strb.setFlag = countEn & extMode & selEdge;
    strb.reinit  = updGen;
    strb.clrFlag = flagClr;
  end

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode != MODE_INT && slaveMode != MODE_EXT1) |-> !strb.inc);
  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |-> (!strb.inc && !strb.setFlag));
  // R7
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && trigSel != TS_ITR && trigSel != TS_ABOTH && trigSel != TS_AFILT
     && trigSel != TS_BFILT && trigSel != TS_EXT) |-> !strb.inc);
endmodule

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  output logic [CNT_W-1:0] count,
  output logic             trigFlag,
  output logic             wrapPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wrapPulse <= 1'b0;
    end else if (strb.reinit) begin
      count     <= '0;
      wrapPulse <= 1'b0;
    end else if (strb.inc) begin
      count     <= count + 1'b1;
      wrapPulse <= (count == CNT_MAX);
    end else begin
      wrapPulse <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              trigFlag <= 1'b0;
    else if (strb.setFlag)  trigFlag <= 1'b1;
    else if (strb.clrFlag)  trigFlag <= 1'b0;
  end

  // R10
  upd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reinit |=> count == '0);
  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.reinit) |=> count == $past(count) + 1'b1);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inc && !strb.reinit) |=> $stable(count));
  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (count == '0 && $past(count) == CNT_MAX));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag |=> trigFlag);
endmodule

// File: rtl/timer_slave_count.sv
module timer_slave_count
  import tss_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       slaveMode,
  input  logic [2:0]       trigSel,
  input  logic             tiBFall,
  input  logic [FILT_W-1:0] filtLen,
  input  logic             countEn,
  input  logic             updGen,
  input  logic             flagClr,
  input  logic             tiA,
  input  logic             tiB,
  input  logic             intTrig,
  input  logic             extTrig,
  output logic [CNT_W-1:0] count,
  output logic             trigFlag,
  output logic             wrapPulse
);
  logic [NUM_SRC-1:0] rawSrc;
  logic [NUM_SRC-1:0] filtSrc;
  ctrlStrb_t          strb;

  assign rawSrc[SRC_ITR] = intTrig;
  assign rawSrc[SRC_A]   = tiA;
  assign rawSrc[SRC_B]   = tiB;
  assign rawSrc[SRC_EXT] = extTrig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [FILT_W-1:0] chanLen;
    if (i == SRC_ITR) begin : g_nofilt
      assign chanLen = '0;
    end else begin : g_filt
      assign chanLen = filtLen;
    end
    tss_filter #(.FILT_W(FILT_W)) u_filt (
      .clk(clk), .rstN(rstN), .len(chanLen),
      .rawIn(rawSrc[i]), .filtOut(filtSrc[i])
    );
  end

  tss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .trigSel(trigSel),
    .tiBFall(tiBFall), .countEn(countEn), .updGen(updGen), .flagClr(flagClr),
    .filtSrc(filtSrc), .strb(strb)
  );

  tss_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .count(count), .trigFlag(trigFlag), .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/tb_timer_slave_count.sv
`timescale 1ns/1ps
module tb_timer_slave_count;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  slaveMode = 3'b000;
  logic [2:0]  trigSel = 3'b000;
  logic        tiBFall = 1'b0;
  logic [3:0]  filtLen = 4'd0;
  logic        countEn = 1'b0;
  logic        updGen = 1'b0;
  logic        flagClr = 1'b0;
  logic        tiA = 1'b0;
  logic        tiB = 1'b0;
  logic        intTrig = 1'b0;
  logic        extTrig = 1'b0;
  logic [15:0] count;
  logic        trigFlag;
  logic        wrapPulse;

  always #2 clk = ~clk;

  timer_slave_count dut (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .trigSel(trigSel),
    .tiBFall(tiBFall), .filtLen(filtLen), .countEn(countEn), .updGen(updGen),
    .flagClr(flagClr), .tiA(tiA), .tiB(tiB), .intTrig(intTrig), .extTrig(extTrig),
    .count(count), .trigFlag(trigFlag), .wrapPulse(wrapPulse)
  );

  typedef struct {
    string       tag;
    logic [15:0] expCount;
    logic        expFlag;
    logic        expWrap;
  } sbItem_t;

  sbItem_t sbq[$];
  event    chkEv;
  int      nChecks = 0;
  int      nFails  = 0;
  bit      finished = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input string tag, input logic [15:0] c,
                           input logic f, input logic w);
    sbItem_t it;
    it.tag = tag; it.expCount = c; it.expFlag = f; it.expWrap = w;
    sbq.push_back(it);
    ->chkEv;
    #0;
  endtask

  initial begin
    forever begin
      @(chkEv);
      while (sbq.size() > 0) begin
        sbItem_t it;
        it = sbq.pop_front();
        nChecks++;
        if (count !== it.expCount || trigFlag !== it.expFlag || wrapPulse !== it.expWrap) begin
          nFails++;
          $display("FAIL %s: count=%h flag=%b wrap=%b expected count=%h flag=%b wrap=%b",
                   it.tag, count, trigFlag, wrapPulse, it.expCount, it.expFlag, it.expWrap);
        end
      end
    end
  end

  // one high/low pulse on a chosen input: 0 tiA, 1 tiB, 2 intTrig, 3 extTrig
  task automatic pulse(input int which, input int hi, input int lo);
    case (which)
      0: tiA = 1'b1;
      1: tiB = 1'b1;
      2: intTrig = 1'b1;
      default: extTrig = 1'b1;
    endcase
    tick(hi);
    tiA = 1'b0; tiB = 1'b0; intTrig = 1'b0; extTrig = 1'b0;
    tick(lo);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expectNow("R2 reset state", 16'd0, 1'b0, 1'b0);

    // R1 internal mode
    countEn = 1'b1; tick(5);
    expectNow("R1 internal count", 16'd5, 1'b0, 1'b0);
    // R2 disabled hold
    countEn = 1'b0; tick(3);
    expectNow("R2 hold when disabled", 16'd5, 1'b0, 1'b0);
    // R10 update beats increment
    countEn = 1'b1; updGen = 1'b1; tick(1); updGen = 1'b0;
    expectNow("R10 update clears", 16'd0, 1'b0, 1'b0);
    // R3 reserved mode stopped
    slaveMode = 3'b010; tick(4);
    expectNow("R3 reserved mode holds", 16'd0, 1'b0, 1'b0);

    // R4 external mode on tiB rising
    slaveMode = 3'b111; trigSel = 3'b110; tiBFall = 1'b0; filtLen = 4'd0;
    tick(2);
    for (int i = 0; i < 3; i++) pulse(1, 3, 3);
    expectNow("R4 tiB rising edges", 16'd3, 1'b1, 1'b0);
    clearFlag();
    expectNow("R9 flag clear", 16'd3, 1'b0, 1'b0);

    // R4 latency: level in at edge k, count at edge k+1
    tiB = 1'b1; tick(1);
    expectNow("R4 no change at filter edge", 16'd3, 1'b0, 1'b0);
    tick(1);
    expectNow("R4 count one edge later", 16'd4, 1'b1, 1'b0);
    tiB = 1'b0; tick(3);

    // R5 falling polarity
    tiBFall = 1'b1;
    for (int i = 0; i < 2; i++) pulse(1, 3, 3);
    expectNow("R5 tiB falling edges", 16'd6, 1'b1, 1'b0);
    tiBFall = 1'b0;

    // R6 both edges of tiA
    trigSel = 3'b100;
    for (int i = 0; i < 2; i++) pulse(0, 3, 3);
    expectNow("R6 tiA both edges", 16'd10, 1'b1, 1'b0);

    // R7 other sources
    trigSel = 3'b101;
    for (int i = 0; i < 2; i++) pulse(0, 3, 3);
    expectNow("R7 tiA rising", 16'd12, 1'b1, 1'b0);
    trigSel = 3'b001;
    for (int i = 0; i < 2; i++) pulse(2, 3, 3);
    expectNow("R7 intTrig rising", 16'd14, 1'b1, 1'b0);
    trigSel = 3'b111;
    for (int i = 0; i < 2; i++) pulse(3, 3, 3);
    expectNow("R7 extTrig rising", 16'd16, 1'b1, 1'b0);
    trigSel = 3'b011;
    for (int w = 0; w < 4; w++) pulse(w, 3, 3);
    expectNow("R7 unused select never counts", 16'd16, 1'b1, 1'b0);

    // R2 edges ignored when disabled
    clearFlag();
    countEn = 1'b0; trigSel = 3'b110;
    pulse(1, 3, 3);
    expectNow("R2 edge ignored when disabled", 16'd16, 1'b0, 1'b0);
    countEn = 1'b1;

    // R8 filter length 3
    filtLen = 4'd3;
    pulse(1, 3, 8);
    expectNow("R8 short pulse rejected", 16'd16, 1'b0, 1'b0);
    pulse(1, 4, 8);
    expectNow("R8 long pulse passes", 16'd17, 1'b1, 1'b0);
    filtLen = 4'd0;
    tick(2);

    // R9 set beats clear
    clearFlag();
    tiB = 1'b1; tick(1);
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
    expectNow("R9 set has priority over clear", 16'd18, 1'b1, 1'b0);
    tiB = 1'b0; tick(3);
    clearFlag();

    // R11 wrap
    slaveMode = 3'b000; countEn = 1'b0;
    updGen = 1'b1; tick(1); updGen = 1'b0;
    countEn = 1'b1; tick(65535);
    expectNow("R11 at max", 16'hFFFF, 1'b0, 1'b0);
    tick(1);
    expectNow("R11 wraps with pulse", 16'h0000, 1'b0, 1'b1);
    tick(1);
    expectNow("R11 pulse lasts one cycle", 16'h0001, 1'b0, 1'b0);

    tick(2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule